// File: doc/BRIEF.md
# Branch Redirect and Flush Controller

This block steers the fetch program counter and squashes wrong-path work in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) in which every conditional branch is predicted not taken. Fetch keeps running sequentially. When a control transfer is confirmed, the block picks the redirect source, drives the new target, and turns the younger slots into bubbles. A slot that becomes a bubble loses its valid bit and its register write enable.

The block holds a small shadow of the pipeline's control state: the valid bit, the transfer kind, the write enable, a prediction flag, the compare outcome and the target for each stage. Each fetched slot enters this shadow with its decoded transfer kind and its target. The datapath's equality result for the branch in execute is supplied on `cmp_eq`. A target-buffer lookup for the fetch slot is modelled as a hit bit plus a target.

Two static configuration bits choose where redirects happen. Unconditional jumps redirect either in fetch, on a buffer hit, or in decode. Conditional branches resolve either in execute or in memory. A counter accumulates every valid slot that was squashed, so that the cycles per instruction can be derived as (retired + bubbles) / retired. The configuration bits are only changed while reset is asserted.

Top module: `brf_redirect_ctl`

## Requirements
- R1: While reset is asserted and afterwards with no valid fetch, `pc_sel` is 0, all flushes are low, `wb_valid` is 0, `redirect_pc` is 0 and `bubble_cnt` is 0.
- R2: `pc_sel` encodes 0 sequential, 1 fetch-stage buffer hit, 2 decode jump, 3 execute branch, 4 memory branch. An instruction of kind 0 (no transfer) causes no redirect and no flush, and `redirect_pc` is 0 whenever `pc_sel` is 0.
- R3: With `cfg_jump_fetch`=1, a jump (kind 1 = plain jump, 2 = jump-and-link) fetched with `btb_hit`=1 gives `pc_sel`=1 and `redirect_pc`=`btb_target` in that same cycle, flushes nothing, and is not redirected again in decode.
- R4: A jump redirects in decode, one cycle after fetch, with `pc_sel`=2 and its own target, flushing only the fetch slot. This applies when `cfg_jump_fetch`=0 (where `btb_hit` is ignored) or when `cfg_jump_fetch`=1 and the buffer missed.
- R5: With `cfg_branch_mem`=0, a taken branch (kind 3 taken when `cmp_eq`=1, kind 4 taken when `cmp_eq`=0) gives `pc_sel`=3 two cycles after fetch and flushes the fetch and decode slots.
- R6: With `cfg_branch_mem`=1, the compare result is captured while the branch is in execute. A taken branch then gives `pc_sel`=4 three cycles after fetch and flushes the fetch, decode and execute slots.
- R7: A branch that is not taken causes no redirect and no flush.
- R8: When several stages request a redirect in the same cycle, the oldest stage wins (memory, then execute, then decode, then fetch). The slot of a younger requester is squashed.
- R9: Flushed slots never reach writeback: of N fetched instructions exactly N minus the bubbles appear with `wb_valid`=1.
- R10: `bubble_cnt` rises by exactly the number of valid slots flushed in each cycle.
- R11: A jump-and-link keeps its write enable through writeback even when it redirected early; the write enable of every unflushed instruction reaches `wb_wen` four cycles after fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_jump_fetch | input | 1 | 1: jumps redirect in fetch on a buffer hit; 0: in decode |
| cfg_branch_mem | input | 1 | 1: branches resolve in memory; 0: in execute |
| f_valid | input | 1 | Fetch slot holds an instruction |
| f_kind | input | 3 | Transfer kind of the fetch slot (0 none, 1 jump, 2 jump-and-link, 3 branch-if-equal, 4 branch-if-not-equal) |
| f_wen | input | 1 | Register write enable of the fetch slot |
| f_target | input | AW | Transfer target carried with the fetch slot |
| btb_hit | input | 1 | Target buffer hit for the fetch slot |
| btb_target | input | AW | Target supplied by the buffer |
| cmp_eq | input | 1 | Operand equality for the instruction in execute |
| pc_sel | output | 3 | Next-PC source |
| redirect_pc | output | AW | Redirect target, 0 when sequential |
| flush_if | output | 1 | Squash the fetch slot |
| flush_id | output | 1 | Squash the decode slot |
| flush_ex | output | 1 | Squash the execute slot |
| wb_valid | output | 1 | Writeback slot holds a live instruction |
| wb_wen | output | 1 | Register write enable in writeback |
| bubble_cnt | output | CW | Count of squashed valid slots |

## Verification
The bench builds the block with 8-bit targets and an 8-bit bubble counter. This keeps every target value distinct and readable and keeps the counter far below wrap in a single run. With these sizes, every pairing of the two configuration bits, the five transfer kinds, both compare outcomes and both buffer-hit values can be swept, each from reset. Each sweep point checks the whole per-cycle redirect trace, the bubble total, the retirement count and the writeback enable, with the expected values derived from the redirect stage. Hand-built sequences place two requesters in the same cycle to reach every priority pairing.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int KIND_W = 3;

    localparam logic [KIND_W-1:0] OP_NONE = 3'd0;
    localparam logic [KIND_W-1:0] OP_J    = 3'd1;
    localparam logic [KIND_W-1:0] OP_JAL  = 3'd2;
    localparam logic [KIND_W-1:0] OP_BEQ  = 3'd3;
    localparam logic [KIND_W-1:0] OP_BNE  = 3'd4;

    typedef enum logic [2:0] {
        SEL_SEQ = 3'd0,
        SEL_BTB = 3'd1,
        SEL_DEC = 3'd2,
        SEL_EXE = 3'd3,
        SEL_MEM = 3'd4
    } pc_sel_e;

    function automatic logic is_jump(input logic [KIND_W-1:0] k);
        return (k == OP_J) || (k == OP_JAL);
    endfunction

    function automatic logic is_cond(input logic [KIND_W-1:0] k);
        return (k == OP_BEQ) || (k == OP_BNE);
    endfunction

    function automatic logic cond_taken(input logic [KIND_W-1:0] k, input logic eq);
        return ((k == OP_BEQ) && eq) || ((k == OP_BNE) && !eq);
    endfunction

endpackage

// File: rtl/brf_ctl_pipe.sv
module brf_ctl_pipe
    import brf_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_valid,
    input  logic [KIND_W-1:0] f_kind,
    input  logic              f_wen,
    input  logic              f_pred,
    input  logic [AW-1:0]     f_target,
    input  logic              cmp_eq,
    input  logic              flush_if,
    input  logic              flush_id,
    input  logic              flush_ex,
    output logic              id_valid,
    output logic [KIND_W-1:0] id_kind,
    output logic              id_pred,
    output logic [AW-1:0]     id_target,
    output logic              ex_valid,
    output logic [KIND_W-1:0] ex_kind,
    output logic [AW-1:0]     ex_target,
    output logic              mem_valid,
    output logic [KIND_W-1:0] mem_kind,
    output logic              mem_eq,
    output logic [AW-1:0]     mem_target,
    output logic              wb_valid,
    output logic              wb_wen
);

    typedef struct packed {
        logic              id_valid;
        logic [KIND_W-1:0] id_kind;
        logic              id_wen;
        logic              id_pred;
        logic [AW-1:0]     id_target;
        logic              ex_valid;
        logic [KIND_W-1:0] ex_kind;
        logic              ex_wen;
        logic [AW-1:0]     ex_target;
        logic              mem_valid;
        logic [KIND_W-1:0] mem_kind;
        logic              mem_wen;
        logic              mem_eq;
        logic [AW-1:0]     mem_target;
        logic              wb_valid;
        logic              wb_wen;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;

        // decode slot: a squashed or empty fetch slot enters as a bubble
        if (flush_if || !f_valid) begin
            pipe_d.id_valid  = 1'b0;
            pipe_d.id_kind   = OP_NONE;
            pipe_d.id_wen    = 1'b0;
            pipe_d.id_pred   = 1'b0;
            pipe_d.id_target = '0;
        end else begin
            pipe_d.id_valid  = 1'b1;
            pipe_d.id_kind   = f_kind;
            pipe_d.id_wen    = f_wen;
            pipe_d.id_pred   = f_pred;
            pipe_d.id_target = f_target;
        end

        if (flush_id) begin
            pipe_d.ex_valid  = 1'b0;
            pipe_d.ex_kind   = OP_NONE;
            pipe_d.ex_wen    = 1'b0;
            pipe_d.ex_target = '0;
        end else begin
            pipe_d.ex_valid  = pipe_q.id_valid;
            pipe_d.ex_kind   = pipe_q.id_kind;
            pipe_d.ex_wen    = pipe_q.id_wen;
            pipe_d.ex_target = pipe_q.id_target;
        end

        // the compare result is captured as the slot leaves execute
        if (flush_ex) begin
            pipe_d.mem_valid  = 1'b0;
            pipe_d.mem_kind   = OP_NONE;
            pipe_d.mem_wen    = 1'b0;
            pipe_d.mem_eq     = 1'b0;
            pipe_d.mem_target = '0;
        end else begin
            pipe_d.mem_valid  = pipe_q.ex_valid;
            pipe_d.mem_kind   = pipe_q.ex_kind;
            pipe_d.mem_wen    = pipe_q.ex_wen;
            pipe_d.mem_eq     = cmp_eq;
            pipe_d.mem_target = pipe_q.ex_target;
        end

        pipe_d.wb_valid = pipe_q.mem_valid;
        pipe_d.wb_wen   = pipe_q.mem_wen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign id_valid   = pipe_q.id_valid;
    assign id_kind    = pipe_q.id_kind;
    assign id_pred    = pipe_q.id_pred;
    assign id_target  = pipe_q.id_target;
    assign ex_valid   = pipe_q.ex_valid;
    assign ex_kind    = pipe_q.ex_kind;
    assign ex_target  = pipe_q.ex_target;
    assign mem_valid  = pipe_q.mem_valid;
    assign mem_kind   = pipe_q.mem_kind;
    assign mem_eq     = pipe_q.mem_eq;
    assign mem_target = pipe_q.mem_target;
    assign wb_valid   = pipe_q.wb_valid;
    assign wb_wen     = pipe_q.wb_wen;

    // R9
    if_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_if |=> (!pipe_q.id_valid && !pipe_q.id_wen));

    // R5
    id_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_id |=> (!pipe_q.ex_valid && !pipe_q.ex_wen));

    // R6
    ex_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ex |=> (!pipe_q.mem_valid && !pipe_q.mem_wen));

endmodule

// File: rtl/brf_redirect_arb.sv
module brf_redirect_arb
    import brf_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              cfg_jump_fetch,
    input  logic              cfg_branch_mem,
    input  logic              f_valid,
    input  logic [KIND_W-1:0] f_kind,
    input  logic              btb_hit,
    input  logic [AW-1:0]     btb_target,
    input  logic              id_valid,
    input  logic [KIND_W-1:0] id_kind,
    input  logic              id_pred,
    input  logic [AW-1:0]     id_target,
    input  logic              ex_valid,
    input  logic [KIND_W-1:0] ex_kind,
    input  logic [AW-1:0]     ex_target,
    input  logic              cmp_eq,
    input  logic              mem_valid,
    input  logic [KIND_W-1:0] mem_kind,
    input  logic              mem_eq,
    input  logic [AW-1:0]     mem_target,
    output pc_sel_e           sel,
    output logic [AW-1:0]     redirect_pc,
    output logic              flush_if,
    output logic              flush_id,
    output logic              flush_ex,
    output logic              f_pred,
    output logic [1:0]        n_flushed
);

    logic mem_take, ex_take, dec_take, fet_take;

    assign mem_take = cfg_branch_mem && mem_valid && is_cond(mem_kind) && cond_taken(mem_kind, mem_eq);
    assign ex_take  = !cfg_branch_mem && ex_valid && is_cond(ex_kind) && cond_taken(ex_kind, cmp_eq);
    assign dec_take = id_valid && is_jump(id_kind) && !id_pred;
    assign fet_take = cfg_jump_fetch && f_valid && btb_hit && is_jump(f_kind);

    assign f_pred = fet_take;

    always_comb begin
        sel         = SEL_SEQ;
        redirect_pc = '0;
        flush_if    = 1'b0;
        flush_id    = 1'b0;
        flush_ex    = 1'b0;
        if (mem_take) begin
            sel         = SEL_MEM;
            redirect_pc = mem_target;
            flush_if    = 1'b1;
            flush_id    = 1'b1;
            flush_ex    = 1'b1;
        end else if (ex_take) begin
            sel         = SEL_EXE;
            redirect_pc = ex_target;
            flush_if    = 1'b1;
            flush_id    = 1'b1;
        end else if (dec_take) begin
            sel         = SEL_DEC;
            redirect_pc = id_target;
            flush_if    = 1'b1;
        end else if (fet_take) begin
            sel         = SEL_BTB;
            redirect_pc = btb_target;
        end
    end

    assign n_flushed = {1'b0, flush_if & f_valid}
                     + {1'b0, flush_id & id_valid}
                     + {1'b0, flush_ex & ex_valid};

endmodule

// File: rtl/brf_bubble_ctr.sv
module brf_bubble_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    inc,
    output logic [CW-1:0] count
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CW'(inc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/brf_redirect_ctl.sv
module brf_redirect_ctl
    import brf_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_jump_fetch,
    input  logic          cfg_branch_mem,
    input  logic          f_valid,
    input  logic [2:0]    f_kind,
    input  logic          f_wen,
    input  logic [AW-1:0] f_target,
    input  logic          btb_hit,
    input  logic [AW-1:0] btb_target,
    input  logic          cmp_eq,
    output logic [2:0]    pc_sel,
    output logic [AW-1:0] redirect_pc,
    output logic          flush_if,
    output logic          flush_id,
    output logic          flush_ex,
    output logic          wb_valid,
    output logic          wb_wen,
    output logic [CW-1:0] bubble_cnt
);

    logic              id_valid, id_pred, ex_valid, mem_valid, mem_eq, f_pred;
    logic [KIND_W-1:0] id_kind, ex_kind, mem_kind;
    logic [AW-1:0]     id_target, ex_target, mem_target;
    logic [1:0]        n_flushed;
    pc_sel_e           sel;

    brf_ctl_pipe #(.AW(AW)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .f_valid    (f_valid),
        .f_kind     (f_kind),
        .f_wen      (f_wen),
        .f_pred     (f_pred),
        .f_target   (f_target),
        .cmp_eq     (cmp_eq),
        .flush_if   (flush_if),
        .flush_id   (flush_id),
        .flush_ex   (flush_ex),
        .id_valid   (id_valid),
        .id_kind    (id_kind),
        .id_pred    (id_pred),
        .id_target  (id_target),
        .ex_valid   (ex_valid),
        .ex_kind    (ex_kind),
        .ex_target  (ex_target),
        .mem_valid  (mem_valid),
        .mem_kind   (mem_kind),
        .mem_eq     (mem_eq),
        .mem_target (mem_target),
        .wb_valid   (wb_valid),
        .wb_wen     (wb_wen)
    );

    brf_redirect_arb #(.AW(AW)) u_arb (
        .cfg_jump_fetch (cfg_jump_fetch),
        .cfg_branch_mem (cfg_branch_mem),
        .f_valid        (f_valid),
        .f_kind         (f_kind),
        .btb_hit        (btb_hit),
        .btb_target     (btb_target),
        .id_valid       (id_valid),
        .id_kind        (id_kind),
        .id_pred        (id_pred),
        .id_target      (id_target),
        .ex_valid       (ex_valid),
        .ex_kind        (ex_kind),
        .ex_target      (ex_target),
        .cmp_eq         (cmp_eq),
        .mem_valid      (mem_valid),
        .mem_kind       (mem_kind),
        .mem_eq         (mem_eq),
        .mem_target     (mem_target),
        .sel            (sel),
        .redirect_pc    (redirect_pc),
        .flush_if       (flush_if),
        .flush_id       (flush_id),
        .flush_ex       (flush_ex),
        .f_pred         (f_pred),
        .n_flushed      (n_flushed)
    );

    brf_bubble_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (n_flushed),
        .count (bubble_cnt)
    );

    assign pc_sel = sel;

    // R8
    older_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_MEM || sel == SEL_EXE) |=> (sel == SEL_SEQ || sel == SEL_BTB));

    // R10
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_SEQ || sel == SEL_BTB) |=> $stable(bubble_cnt));

endmodule

// File: tb/brf_redirect_ctl_bench.sv
module brf_redirect_ctl_bench;

    localparam int AW = 8;
    localparam int CW = 8;
    localparam logic [2:0] K_NONE = 3'd0, K_J = 3'd1, K_JAL = 3'd2, K_BEQ = 3'd3, K_BNE = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_jump_fetch = 1'b0, cfg_branch_mem = 1'b0;
    logic          f_valid = 1'b0, f_wen = 1'b0, btb_hit = 1'b0, cmp_eq = 1'b0;
    logic [2:0]    f_kind = '0;
    logic [AW-1:0] f_target = '0, btb_target = '0;
    logic [2:0]    pc_sel;
    logic [AW-1:0] redirect_pc;
    logic          flush_if, flush_id, flush_ex, wb_valid, wb_wen;
    logic [CW-1:0] bubble_cnt;

    always #5 clk = ~clk;

    brf_redirect_ctl #(.AW(AW), .CW(CW)) u_brf_redirect_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_jump_fetch(cfg_jump_fetch), .cfg_branch_mem(cfg_branch_mem),
        .f_valid(f_valid), .f_kind(f_kind), .f_wen(f_wen), .f_target(f_target),
        .btb_hit(btb_hit), .btb_target(btb_target), .cmp_eq(cmp_eq),
        .pc_sel(pc_sel), .redirect_pc(redirect_pc), .flush_if(flush_if), .flush_id(flush_id),
        .flush_ex(flush_ex), .wb_valid(wb_valid), .wb_wen(wb_wen), .bubble_cnt(bubble_cnt)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [2:0]    pk [0:7];
    logic          ph [0:7];
    logic [2:0]    es [0:12];
    logic [AW-1:0] ep [0:12];
    logic [2:0]    ef [0:12];
    int            enb;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic do_reset(input bit jf, input bit bm);
        @(negedge clk);
        rst_n = 1'b0; f_valid = 1'b0; btb_hit = 1'b0; f_wen = 1'b0; f_kind = K_NONE;
        cfg_jump_fetch = jf; cfg_branch_mem = bm;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 8; i++) begin pk[i] = K_NONE; ph[i] = 1'b0; end
        for (int c = 0; c < 13; c++) begin es[c] = 3'd0; ep[c] = '0; ef[c] = 3'd0; end
        enb = 0;
    endtask

    task automatic run_prog(input bit jf, input bit bm, input bit eq, input string tag);
        int retired = 0;
        int bad_c = -1;
        int bad_act = 0;
        logic wbv4 = 1'b0, wbw4 = 1'b0, exp_w;
        do_reset(jf, bm);
        cmp_eq = eq;
        for (int c = 0; c < 13; c++) begin
            @(negedge clk);
            f_valid    = (c < 8);
            f_kind     = (c < 8) ? pk[c] : K_NONE;
            f_wen      = (c < 8) ? (pk[c] == K_NONE || pk[c] == K_JAL) : 1'b0;
            btb_hit    = (c < 8) ? ph[c] : 1'b0;
            f_target   = AW'(8'h40 + c);
            btb_target = AW'(8'h80 + c);
            #1;
            if (wb_valid) retired++;
            if (c == 4) begin wbv4 = wb_valid; wbw4 = wb_wen; end
            if (bad_c < 0 && (pc_sel != es[c] || redirect_pc != ep[c] ||
                              {flush_if, flush_id, flush_ex} != ef[c])) begin
                bad_c   = c;
                bad_act = {24'd0, pc_sel, flush_if, flush_id, flush_ex} * 256 + int'(redirect_pc);
            end
        end
        check(bad_c < 0, tag, "redirect trace (sel,flushes,pc) at first bad cycle", bad_act,
              (bad_c < 0) ? 0 : ({24'd0, es[bad_c], ef[bad_c]} * 256 + int'(ep[bad_c])));
        f_valid = 1'b0;
        @(negedge clk); #1;
        check(bubble_cnt == CW'(enb), "R10", "bubble count", int'(bubble_cnt), enb);
        check(retired == 8 - enb, "R9", "retired instructions", retired, 8 - enb);
        exp_w = (pk[0] == K_NONE || pk[0] == K_JAL);
        check(wbv4 == 1'b1 && wbw4 == exp_w, "R11", "writeback enable of first instruction",
              {wbv4, wbw4}, {1'b1, exp_w});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        // R1 reset state
        do_reset(1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk); #1;
        check(pc_sel == 3'd0 && !flush_if && !flush_id && !flush_ex, "R1", "sel/flush in reset",
              {pc_sel, flush_if, flush_id, flush_ex}, 0);
        check(wb_valid == 1'b0, "R1", "wb_valid in reset", wb_valid, 0);
        check(bubble_cnt == '0, "R1", "bubble count in reset", int'(bubble_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(redirect_pc == '0 && pc_sel == 3'd0, "R1", "idle redirect", int'(redirect_pc), 0);
        check(wb_valid == 1'b0 && bubble_cnt == '0, "R1", "idle after reset",
              {wb_valid, bubble_cnt}, 0);

        // sweep: configurations x kinds x compare outcome x buffer hit
        for (int jf = 0; jf < 2; jf++)
        for (int bm = 0; bm < 2; bm++)
        for (int k = 0; k < 5; k++)
        for (int eq = 0; eq < 2; eq++)
        for (int hit = 0; hit < 2; hit++) begin
            string tag;
            bit taken;
            clear_prog();
            pk[0] = 3'(k);
            ph[0] = hit[0];
            tag = "R2";
            if (k == K_J || k == K_JAL) begin
                if (jf == 1 && hit == 1) begin
                    tag = "R3"; es[0] = 3'd1; ep[0] = AW'(8'h80);
                end else begin
                    tag = "R4"; es[1] = 3'd2; ep[1] = AW'(8'h40); ef[1] = 3'b100; enb = 1;
                end
            end else if (k == K_BEQ || k == K_BNE) begin
                taken = (k == K_BEQ) ? eq[0] : !eq[0];
                if (!taken) tag = "R7";
                else if (bm == 1) begin
                    tag = "R6"; es[3] = 3'd4; ep[3] = AW'(8'h40); ef[3] = 3'b111; enb = 3;
                end else begin
                    tag = "R5"; es[2] = 3'd3; ep[2] = AW'(8'h40); ef[2] = 3'b110; enb = 2;
                end
            end
            run_prog(jf[0], bm[0], eq[0], tag);
        end

        // R8 memory branch beats a decode jump in the same cycle
        clear_prog();
        pk[0] = K_BEQ; pk[2] = K_J;
        es[3] = 3'd4; ep[3] = AW'(8'h40); ef[3] = 3'b111; enb = 3;
        run_prog(1'b0, 1'b1, 1'b1, "R8");

        // R8 execute branch beats a decode jump
        clear_prog();
        pk[0] = K_BEQ; pk[1] = K_J;
        es[2] = 3'd3; ep[2] = AW'(8'h40); ef[2] = 3'b110; enb = 2;
        run_prog(1'b0, 1'b0, 1'b1, "R8");

        // R8 execute branch beats a fetch-stage buffer hit
        clear_prog();
        pk[0] = K_BNE; pk[2] = K_J; ph[2] = 1'b1;
        es[2] = 3'd3; ep[2] = AW'(8'h40); ef[2] = 3'b110; enb = 2;
        run_prog(1'b1, 1'b0, 1'b0, "R8");

        // R8 decode jump (buffer miss) beats a fetch-stage hit
        clear_prog();
        pk[0] = K_JAL; pk[1] = K_J; ph[1] = 1'b1;
        es[1] = 3'd2; ep[1] = AW'(8'h40); ef[1] = 3'b100; enb = 1;
        run_prog(1'b1, 1'b0, 1'b1, "R8");

        finish_up();
    end

endmodule